// File: doc/BRIEF.md
# Internal Memory and Register Space Access Router

This block sits between a small microcontroller core and its on-chip storage. It has two targets: a byte-wide internal RAM, and a bus that reaches the special-function registers (SFRs). For each access the core presents an 8-bit address, an access kind, a write flag and write data. The access kind decides where the address lands. For the same upper address range, 80h to FFh, a direct access reaches the register bus and a pointer-based (indirect) access reaches the upper half of the RAM. A single-bit access maps a bit number onto a containing byte, which is either a byte in a fixed RAM window or a register whose address is a multiple of eight.

Single-bit writes are done as one-cycle read-modify-write operations. The containing byte is read, only the addressed bit is replaced, and the byte is written back in the same cycle. Read results, whether a byte or a bit, are registered and appear one cycle after the request. The RAM is held inside the block. The registers themselves live outside it and answer on the register bus with an acknowledge line that marks an address as populated.

Top module: `iram_sfr_router`

## Requirements
- R1: An indirect access (req_mode 01) reaches RAM for every address 00h–FFh and never asserts sfr_re or sfr_we.
- R2: A direct access (req_mode 00) to 00h–7Fh reaches RAM and never asserts sfr_re or sfr_we.
- R3: A direct access to 80h–FFh drives the register bus with sfr_addr equal to req_addr and sfr_wdata equal to req_wdata on writes. It leaves RAM unchanged.
- R4: A bit access (req_mode 10) with bit number below 80h uses RAM byte 20h + (n >> 3), bit n & 7. A bit read returns the bit in rd_data[0] with rd_data[7:1] zero.
- R5: A bit access with bit number 80h–FFh uses register byte n & F8h, bit n & 7, on the register bus.
- R6: A bit write takes the bit value from req_wdata[0] and changes only the addressed bit of the containing byte. All other bits keep their prior values.
- R7: A direct read of a register address whose sfr_ack is low returns 00h.
- R8: rd_valid and rd_data appear in the cycle after a read request. A write is visible to a read issued in the next cycle.
- R9: req_mode 11 is reserved. It changes no storage, asserts no bus strobe and gives no rd_valid.
- R10: After reset, rd_valid and rd_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request in this cycle |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 bit, 11 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Byte address or bit number |
| req_wdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read byte, or bit in bit 0 |
| sfr_addr | output | 8 | Register bus address |
| sfr_re | output | 1 | Register bus read strobe |
| sfr_we | output | 1 | Register bus write strobe |
| sfr_wdata | output | 8 | Register bus write data |
| sfr_rdata | input | 8 | Register bus read data, same cycle |
| sfr_ack | input | 1 | Addressed register exists |

## Verification
The bench goes after the upper half of the address space. A design that let direct accesses reach RAM there, or indirect accesses reach the register bus, would corrupt data that the indirect readback sweep then finds. Every bit number from 00h to FFh is read, inverted and read back as a whole byte. A wrong shift or base in the bit-to-byte mapping, or a write-back that clobbers neighbouring bits, would show up as a wrong byte. Reads of unpopulated register addresses must come back as zero, not as stale bus data. The reserved mode must leave storage untouched and raise no read-valid.

// File: rtl/iram_sfr_pkg.sv
package iram_sfr_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      ACC_DIRECT   = 2'b00,
      ACC_INDIRECT = 2'b01,
      ACC_BIT      = 2'b10,
      ACC_RSVD     = 2'b11
   } acc_mode_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'b00,
      TGT_RAM  = 2'b01,
      TGT_SFR  = 2'b10
   } tgt_e;

   typedef struct packed {
      tgt_e               tgt;
      logic               is_bit;
      logic [BYTE_W-1:0]  byte_addr;
      logic [2:0]         bit_idx;
   } route_t;
endpackage

// File: rtl/iram_sfr_decode.sv
module iram_sfr_decode
   import iram_sfr_pkg::*;
#(
   parameter logic [BYTE_W-1:0] BIT_BASE  = 8'h20,
   parameter bit                UPPER_RAM = 1'b1
) (
   input  logic              valid,
   input  logic [1:0]        mode,
   input  logic [BYTE_W-1:0] addr,
   output route_t            route
);
   always_comb begin
      route = '0;
      unique case (acc_mode_e'(mode))
         ACC_DIRECT: begin
            route.tgt       = addr[7] ? TGT_SFR : TGT_RAM;
            route.byte_addr = addr;
         end
         ACC_INDIRECT: begin
            route.tgt       = (addr[7] && !UPPER_RAM) ? TGT_NONE : TGT_RAM;
            route.byte_addr = addr;
         end
         ACC_BIT: begin
            route.is_bit  = 1'b1;
            route.bit_idx = addr[2:0];
            if (addr[7]) begin
               route.tgt       = TGT_SFR;
               route.byte_addr = {addr[7:3], 3'b000};
            end else begin
               route.tgt       = TGT_RAM;
               route.byte_addr = BIT_BASE + {4'b0000, addr[6:3]};
            end
         end
         default: route = '0;
      endcase
      if (!valid) route.tgt = TGT_NONE;
   end
endmodule

// File: rtl/iram_sfr_bitmerge.sv
module iram_sfr_bitmerge
   import iram_sfr_pkg::*;
(
   input  logic [BYTE_W-1:0] old_byte,
   input  logic [2:0]        bit_idx,
   input  logic              bit_val,
   output logic [BYTE_W-1:0] new_byte,
   output logic              bit_out
);
   for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign new_byte[i] = (bit_idx == 3'(i)) ? bit_val : old_byte[i];
   end
   assign bit_out = old_byte[bit_idx];
endmodule

// File: rtl/iram_sfr_ram.sv
module iram_sfr_ram
   import iram_sfr_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/iram_sfr_router.sv
module iram_sfr_router
   import iram_sfr_pkg::*;
#(
   parameter int unsigned       RAM_BYTES = 256,
   parameter logic [BYTE_W-1:0] BIT_BASE  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic              req_write,
   input  logic [7:0]        req_addr,
   input  logic [7:0]        req_wdata,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic [7:0]        sfr_addr,
   output logic              sfr_re,
   output logic              sfr_we,
   output logic [7:0]        sfr_wdata,
   input  logic [7:0]        sfr_rdata,
   input  logic              sfr_ack
);
   localparam int unsigned AW        = $clog2(RAM_BYTES);
   localparam bit          UPPER_RAM = (RAM_BYTES == 256);

   if (!(RAM_BYTES == 128 || RAM_BYTES == 256)) begin : g_bad_depth
      $error("RAM_BYTES must be 128 or 256");
   end
   if (BIT_BASE[7] || BIT_BASE > 8'h70) begin : g_bad_base
      $error("BIT_BASE window must lie in the low half");
   end

   route_t            rt;
   logic [BYTE_W-1:0] ram_q, cur_byte, merged, result;
   logic              bit_out, ram_we;

   iram_sfr_decode #(.BIT_BASE(BIT_BASE), .UPPER_RAM(UPPER_RAM)) u_dec (
      .valid (req_valid),
      .mode  (req_mode),
      .addr  (req_addr),
      .route (rt)
   );

   assign ram_we = (rt.tgt == TGT_RAM) && req_write;

   iram_sfr_ram #(.DEPTH(RAM_BYTES)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (rt.byte_addr[AW-1:0]),
      .wdata (rt.is_bit ? merged : req_wdata),
      .rdata (ram_q)
   );

   always_comb begin
      if (rt.tgt == TGT_SFR) cur_byte = sfr_ack ? sfr_rdata : '0;
      else                   cur_byte = ram_q;
   end

   iram_sfr_bitmerge u_merge (
      .old_byte (cur_byte),
      .bit_idx  (rt.bit_idx),
      .bit_val  (req_wdata[0]),
      .new_byte (merged),
      .bit_out  (bit_out)
   );

   assign sfr_addr  = rt.byte_addr;
   assign sfr_re    = (rt.tgt == TGT_SFR) && (!req_write || rt.is_bit);
   assign sfr_we    = (rt.tgt == TGT_SFR) && req_write && (!rt.is_bit || sfr_ack);
   assign sfr_wdata = rt.is_bit ? merged : req_wdata;
   assign result    = rt.is_bit ? {7'b0, bit_out} : cur_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= (rt.tgt != TGT_NONE) && !req_write;
         if ((rt.tgt != TGT_NONE) && !req_write) rd_data <= result;
      end
   end
endmodule

// File: rtl/iram_sfr_router_chk.sv
module iram_sfr_router_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_mode,
   input logic       req_write,
   input logic [7:0] req_addr,
   input logic [7:0] req_wdata,
   input logic       rd_valid,
   input logic [7:0] rd_data,
   input logic [7:0] sfr_addr,
   input logic       sfr_re,
   input logic       sfr_we,
   input logic [7:0] sfr_wdata,
   input logic [7:0] sfr_rdata,
   input logic       sfr_ack
);
   AST_INDIRECT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b01) |-> (!sfr_re && !sfr_we)); // R1
   AST_DIRECT_LOW_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b00 && !req_addr[7]) |-> (!sfr_re && !sfr_we)); // R2
   AST_DIRECT_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b00 && req_addr[7] && !req_write) |-> (sfr_re && sfr_addr == req_addr)); // R3
   AST_DIRECT_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b00 && req_addr[7] && req_write) |-> (sfr_we && sfr_wdata == req_wdata)); // R3
   AST_BIT_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b10 && !req_write) |=> (rd_data[7:1] == 7'd0)); // R4
   AST_BIT_SFR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b10 && req_addr[7]) |-> (sfr_addr == {req_addr[7:3], 3'b000})); // R5
   AST_BIT_SINGLE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b10 && req_addr[7] && req_write && sfr_ack) |-> (sfr_we && $countones(sfr_wdata ^ sfr_rdata) <= 1)); // R6
   AST_UNACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 2'b00 && req_addr[7] && !req_write && !sfr_ack) |=> (rd_data == 8'h00)); // R7
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_mode != 2'b11) |=> rd_valid); // R8
   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mode == 2'b11) |-> (!sfr_re && !sfr_we)); // R9
   AST_RSVD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (req_mode == 2'b11 || !req_valid) |=> !rd_valid); // R9
endmodule

bind iram_sfr_router iram_sfr_router_chk u_chk (.*);

// File: tb/iram_sfr_router_bench.sv
module iram_sfr_router_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = 2'b00;
   logic       req_write = 1'b0;
   logic [7:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
   logic       sfr_re, sfr_we, sfr_ack;

   logic [7:0] sfr_regs [128];
   logic [7:0] exp_ram [256];
   logic [7:0] exp_sfr [128];
   int         n_checks = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic populated(input logic [7:0] a);
      return (a[2:0] == 3'b000) || a == 8'h81 || a == 8'h99;
   endfunction

   assign sfr_ack   = populated(sfr_addr);
   assign sfr_rdata = sfr_ack ? sfr_regs[sfr_addr[6:0]] : 8'hA5;

   always @(posedge clk) begin
      if (sfr_we && sfr_ack) sfr_regs[sfr_addr[6:0]] <= sfr_wdata;
   end

   iram_sfr_router u_iram_sfr_router (
      .clk, .rst_n, .req_valid, .req_mode, .req_write, .req_addr, .req_wdata,
      .rd_valid, .rd_data, .sfr_addr, .sfr_re, .sfr_we, .sfr_wdata,
      .sfr_rdata, .sfr_ack
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] m, input logic w, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin sfr_regs[i] = 8'h00; exp_sfr[i] = 8'h00; end
      repeat (3) @(negedge clk);
      // R10: reset values
      chk("R10 rd_valid", {7'b0, rd_valid}, 8'h00);
      chk("R10 rd_data", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle no rd_valid", {7'b0, rd_valid}, 8'h00);

      // R1: fill the whole RAM through pointer accesses and read it back
      for (int a = 0; a < 256; a++) begin
         exp_ram[a] = 8'(a) ^ 8'h5A;
         acc(2'b01, 1'b1, 8'(a), exp_ram[a]);
      end
      for (int a = 0; a < 256; a++) begin
         acc(2'b01, 1'b0, 8'(a), 8'h00);
         chk("R1 indirect read", rd_data, exp_ram[a]);
         chk("R8 rd_valid", {7'b0, rd_valid}, 8'h01);
      end

      // R2: direct lower half
      for (int a = 0; a < 128; a++) begin
         exp_ram[a] = ~8'(a);
         acc(2'b00, 1'b1, 8'(a), exp_ram[a]);
         acc(2'b00, 1'b0, 8'(a), 8'h00);
         chk("R2 direct low read", rd_data, exp_ram[a]);
      end

      // R3/R7: direct upper half goes to the register bus
      for (int a = 128; a < 256; a++) begin
         if (populated(8'(a))) exp_sfr[a-128] = 8'(a + 3);
         acc(2'b00, 1'b1, 8'(a), 8'(a + 3));
      end
      for (int a = 128; a < 256; a++) begin
         acc(2'b00, 1'b0, 8'(a), 8'h00);
         if (populated(8'(a))) chk("R3 direct sfr read", rd_data, exp_sfr[a-128]);
         else                  chk("R7 unpopulated sfr read", rd_data, 8'h00);
         acc(2'b01, 1'b0, 8'(a), 8'h00);
         chk("R3 upper RAM untouched", rd_data, exp_ram[a]);
      end

      // R4/R5/R6: every bit number, read, invert, read whole byte
      for (int b = 0; b < 256; b++) begin
         logic [7:0] ba, old, nb;
         logic       nv;
         ba  = (b < 128) ? 8'(8'h20 + (b >> 3)) : 8'(b & 8'hF8);
         old = (b < 128) ? exp_ram[ba] : exp_sfr[ba[6:0]];
         acc(2'b10, 1'b0, 8'(b), 8'h00);
         chk((b < 128) ? "R4 bit read" : "R5 bit read", rd_data, {7'b0, old[b & 7]});
         nv = ~old[b & 7];
         nb = old;
         nb[b & 7] = nv;
         acc(2'b10, 1'b1, 8'(b), {7'b1111111, nv});
         if (b < 128) exp_ram[ba] = nb; else exp_sfr[ba[6:0]] = nb;
         acc(2'b00, 1'b0, ba, 8'h00);
         chk("R6 byte after bit write", rd_data, nb);
      end

      // R9: reserved mode leaves storage alone
      acc(2'b11, 1'b1, 8'h10, 8'hFF);
      acc(2'b11, 1'b1, 8'h90, 8'hFF);
      acc(2'b11, 1'b0, 8'h10, 8'h00);
      chk("R9 reserved read no valid", {7'b0, rd_valid}, 8'h00);
      acc(2'b00, 1'b0, 8'h10, 8'h00);
      chk("R9 RAM unchanged", rd_data, exp_ram[8'h10]);
      acc(2'b00, 1'b0, 8'h90, 8'h00);
      chk("R9 sfr unchanged", rd_data, exp_sfr[8'h10]);
      @(negedge clk);
      chk("R8 rd_valid drops when idle", {7'b0, rd_valid}, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule